// File: doc/BRIEF.md
# Dual-Channel Serial Wiper Code Register

This block is the digital control core of a two-channel, 256-step resistor-wiper device. A host writes position codes over a three-wire serial link made of an active-low select, a serial clock and a data line. Each frame is ten bits long. The first two bits are an address, and only the lower of the two picks the channel. The remaining eight bits are the wiper code. When the select line returns high, the code is written into the position latch of the chosen channel. The bit that drops off the far end of the shift register goes out on a serial output, so several of these blocks can be chained on one select line.

All serial pins, and the shutdown pin, are sampled by a fast system clock through short synchronizer chains. A four-state machine tracks the frame. IDLE waits for the select line to fall and then clears the bit counter (IDLE to SHIFT). SHIFT accepts one bit on each rising serial clock edge. When the select line rises, SHIFT goes to LOAD if exactly ten bits arrived, and to DROP otherwise. LOAD issues a one-cycle write to the channel latches and returns to IDLE. DROP returns to IDLE without writing anything. Reset places both latches at midscale.

A shutdown input raises two flags per channel. One flag opens terminal A and the other ties the wiper to terminal B. The latches keep their contents while shutdown is high, and they still accept new codes, which take effect once shutdown is released.

Top module: `wiper_ctl_top`

## Requirements
- R1: After reset, both channel codes read 128 (0x80), all shutdown flags are low and the serial output is 0.
- R2: A frame of exactly 10 serial clock rising edges between select falling and rising is taken MSB first as {address[1:0], code[7:0]}, and the code is written to the addressed channel after select rises.
- R3: Address bit 0 (the second bit shifted in) selects the channel: 0 writes channel 1 (`wiper_code[7:0]`) and 1 writes channel 2 (`wiper_code[15:8]`). Address bit 1 (the first bit shifted in) has no effect on which channel is written.
- R4: A frame with any bit count other than 10, whether shorter or longer, leaves both channel codes unchanged.
- R5: The serial output presents, after the falling serial clock edge of clock k, the bit that was shifted in on clock k-10, counted across frames. This gives a ten-clock pass-through for daisy chaining.
- R6: While shutdown is high, every channel's terminal-A-open and wiper-to-B flags are high. When shutdown is low, all of these flags are low.
- R7: Shutdown never changes the channel codes. Frames written during shutdown update the codes exactly as they do outside shutdown.
- R8: Serial clock edges while select is high neither shift the register nor change the serial output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| cs_n | input | 1 | Serial frame select, active low |
| sck | input | 1 | Serial clock; data sampled on its rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| shutdown | input | 1 | High requests the low-power terminal state |
| sdo | output | 1 | Serial data out for daisy chaining, updated after falling sck edges |
| wiper_code | output | 16 | Channel codes: [7:0] channel 1, [15:8] channel 2 |
| term_a_open | output | 2 | Per channel, terminal A open request |
| wiper_to_b | output | 2 | Per channel, wiper-to-terminal-B short request |

## Verification
Every pin passes through a two-stage synchronizer, so a change at a pin is seen internally two system clocks later. After a rising select edge, the state machine enters LOAD on the next clock and the latch updates one clock after that, so a code lands four clocks after select rises. The serial output and the shutdown flags each settle three clocks after their triggering edge. The bench holds every serial half-period for eight clocks, reads the serial output eight clocks after each falling edge, and checks the codes and flags twelve clocks after select rises or six clocks after shutdown changes, so every read happens well after its result is due.

// File: rtl/wiper_ctl_pkg.sv
package wiper_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2,
        ST_DROP  = 2'd3
    } ser_state_t;

endpackage

// File: rtl/wiper_pin_sync.sv
module wiper_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level
);

    logic [STAGES-1:0] chain_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= RST_VAL;
                else        chain_q[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= RST_VAL;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign level = chain_q[STAGES-1];

endmodule

// File: rtl/wiper_serial_fsm.sv
module wiper_serial_fsm
    import wiper_ctl_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int CODE_W = 8,
    parameter int SEL_W  = 1,
    localparam int FRAME_W = ADDR_W + CODE_W,
    localparam int CNT_W   = $clog2(FRAME_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              sck_lvl,
    input  logic              sdi_lvl,
    output logic              load_stb,
    output logic [SEL_W-1:0]  load_sel,
    output logic [CODE_W-1:0] load_code,
    output logic              sdo
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    ser_state_t         state_q, state_d;
    logic               cs_prev_q, sck_prev_q;
    logic               cs_rise, cs_fall, sck_rise, sck_fall;
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               out_bit_q;
    logic               sdo_q;

    assign cs_rise  =  cs_lvl  & ~cs_prev_q;
    assign cs_fall  = ~cs_lvl  &  cs_prev_q;
    assign sck_rise =  sck_lvl & ~sck_prev_q;
    assign sck_fall = ~sck_lvl &  sck_prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_fall) state_d = ST_SHIFT;
            ST_SHIFT: if (cs_rise) state_d = (cnt_q == CNT_FULL) ? ST_LOAD : ST_DROP;
            ST_LOAD:  state_d = ST_IDLE;
            ST_DROP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // shift path, bit counter and daisy-chain output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev_q  <= 1'b1;
            sck_prev_q <= 1'b0;
            shreg_q    <= '0;
            cnt_q      <= '0;
            out_bit_q  <= 1'b0;
            sdo_q      <= 1'b0;
        end else begin
            cs_prev_q  <= cs_lvl;
            sck_prev_q <= sck_lvl;
            if (state_q == ST_IDLE && cs_fall) begin
                cnt_q <= '0;
            end
            if (state_q == ST_SHIFT && sck_rise) begin
                out_bit_q <= shreg_q[FRAME_W-1];
                shreg_q   <= {shreg_q[FRAME_W-2:0], sdi_lvl};
                if (cnt_q != CNT_OVER) cnt_q <= cnt_q + CNT_ONE;
            end
            if (state_q == ST_SHIFT && sck_fall) begin
                sdo_q <= out_bit_q;
            end
        end
    end

    // outputs
    always_comb begin
        load_stb  = (state_q == ST_LOAD);
        load_sel  = shreg_q[CODE_W +: SEL_W];
        load_code = shreg_q[CODE_W-1:0];
        sdo       = sdo_q;
    end

    // R2: a latch write always follows a rising select edge
    p_load_after_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> $past(cs_rise));

    // R4: a wrong bit count ends in the drop state
    p_bad_count_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && cs_rise && cnt_q != CNT_FULL) |=> (state_q == ST_DROP));

    // R5: the serial output moves only after a falling serial clock edge
    p_sdo_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(sdo_q));

    // R8: nothing shifts outside a frame
    p_idle_no_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(shreg_q));

endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
    parameter int NCH    = 2,
    parameter int CODE_W = 8,
    parameter int SEL_W  = 1,
    localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W - 1))
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_stb,
    input  logic [SEL_W-1:0]      load_sel,
    input  logic [CODE_W-1:0]     load_code,
    input  logic                  shdn_lvl,
    output logic [NCH*CODE_W-1:0] wiper_code,
    output logic [NCH-1:0]        term_a_open,
    output logic [NCH-1:0]        wiper_to_b
);

    logic [NCH-1:0][CODE_W-1:0] latch_q;
    logic [NCH-1:0]             open_q, short_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                latch_q[c] <= MID;
                open_q[c]  <= 1'b0;
                short_q[c] <= 1'b0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (load_stb && load_sel == SEL_W'(c)) latch_q[c] <= load_code;
                open_q[c]  <= shdn_lvl;
                short_q[c] <= shdn_lvl;
            end
        end
    end

    assign wiper_code  = latch_q;
    assign term_a_open = open_q;
    assign wiper_to_b  = short_q;

    // R7: codes change only on a write strobe, whatever shutdown does
    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> $stable(latch_q));

    // R6: entering shutdown raises every flag on the next clock
    p_flags_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shdn_lvl) |=> (&term_a_open && &wiper_to_b));

endmodule

// File: rtl/wiper_ctl_top.sv
module wiper_ctl_top #(
    parameter int NCH         = 2,
    parameter int CODE_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sck,
    input  logic                  sdi,
    input  logic                  shutdown,
    output logic                  sdo,
    output logic [NCH*CODE_W-1:0] wiper_code,
    output logic [NCH-1:0]        term_a_open,
    output logic [NCH-1:0]        wiper_to_b
);

    logic cs_lvl, sck_lvl, sdi_lvl, shdn_lvl;
    logic              load_stb;
    logic [SEL_W-1:0]  load_sel;
    logic [CODE_W-1:0] load_code;

    wiper_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_cs (
        .clk(clk), .rst_n(rst_n), .din(cs_n), .level(cs_lvl));
    wiper_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sck (
        .clk(clk), .rst_n(rst_n), .din(sck), .level(sck_lvl));
    wiper_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sdi (
        .clk(clk), .rst_n(rst_n), .din(sdi), .level(sdi_lvl));
    wiper_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_shdn (
        .clk(clk), .rst_n(rst_n), .din(shutdown), .level(shdn_lvl));

    wiper_serial_fsm #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .SEL_W(SEL_W)) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .cs_lvl(cs_lvl), .sck_lvl(sck_lvl), .sdi_lvl(sdi_lvl),
        .load_stb(load_stb), .load_sel(load_sel), .load_code(load_code),
        .sdo(sdo));

    wiper_bank #(.NCH(NCH), .CODE_W(CODE_W), .SEL_W(SEL_W)) i_bank (
        .clk(clk), .rst_n(rst_n),
        .load_stb(load_stb), .load_sel(load_sel), .load_code(load_code),
        .shdn_lvl(shdn_lvl),
        .wiper_code(wiper_code), .term_a_open(term_a_open), .wiper_to_b(wiper_to_b));

    // R6: both flag sets agree and the terminal state is all-or-none
    p_flags_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (term_a_open == wiper_to_b) && ($countones(term_a_open) == 0 || &term_a_open));

endmodule

// File: tb/test_wiper_ctl_top.sv
module test_wiper_ctl_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        shutdown = 1'b0;
    logic        sdo;
    logic [15:0] wiper_code;
    logic [1:0]  term_a_open;
    logic [1:0]  wiper_to_b;

    int          checks = 0;
    int          errors = 0;
    logic [7:0]  exp_code [2];
    logic        seen [32];
    logic        shdn_model = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_ctl_top i_wiper_ctl_top (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .shutdown(shutdown), .sdo(sdo), .wiper_code(wiper_code),
        .term_a_open(term_a_open), .wiper_to_b(wiper_to_b));

    function automatic logic [31:0] mk_word(input logic [1:0] addr, input logic [7:0] code);
        return {22'd0, addr, code};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk({req, " ch1 code"}, {24'd0, wiper_code[7:0]},  {24'd0, exp_code[0]});
        chk({req, " ch2 code"}, {24'd0, wiper_code[15:8]}, {24'd0, exp_code[1]});
        chk({req, " A open"},   {30'd0, term_a_open}, {30'd0, {2{shdn_model}}});
        chk({req, " W to B"},   {30'd0, wiper_to_b},  {30'd0, {2{shdn_model}}});
    endtask

    task automatic send(input int nb, input logic [31:0] w);
        cs_n = 1'b0;
        idle(HALF);
        for (int k = 0; k < nb; k++) begin
            sdi = w[nb-1-k];
            idle(HALF);
            sck = 1'b1;
            idle(HALF);
            sck = 1'b0;
            idle(HALF);
            seen[k] = sdo;
        end
        cs_n = 1'b1;
        idle(12);
        if (nb == 10) exp_code[w[8]] = w[7:0];
    endtask

    task automatic set_shdn(input logic v);
        shutdown   = v;
        shdn_model = v;
        idle(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] a_word, b_word, long_word, w;
        int nb;
        void'($urandom(32'd20240611));
        exp_code[0] = 8'h80;
        exp_code[1] = 8'h80;
        idle(4);
        rst_n = 1'b1;
        idle(4);

        // R1: midscale after reset
        check_all("R1 reset");
        chk("R1 sdo", {31'd0, sdo}, 32'd0);

        // R2, R3: direct writes to each channel
        send(10, mk_word(2'b00, 8'h00));
        check_all("R2 ch1 zero");
        send(10, mk_word(2'b01, 8'hFF));
        check_all("R2 ch2 full");
        // R3: the upper address bit does not change the target
        send(10, mk_word(2'b10, 8'h5A));
        check_all("R3 addr 10 to ch1");
        send(10, mk_word(2'b11, 8'hA5));
        check_all("R3 addr 11 to ch2");

        // R4: short and long frames are discarded
        send(9, 32'h1FF);
        check_all("R4 nine bits");
        send(11, 32'h3FF);
        check_all("R4 eleven bits");

        // R5: twenty clocks, second half of sdo equals first half of input
        long_word = $urandom & 32'h000F_FFFF;
        send(20, long_word);
        check_all("R4 twenty bits");
        for (int k = 10; k < 20; k++)
            chk("R5 daisy delay", {31'd0, seen[k]}, {31'd0, long_word[19-(k-10)]});

        // R8: clocks with select high do not disturb the register
        a_word = mk_word(2'b00, 8'h3C);
        b_word = mk_word(2'b01, 8'hC3);
        send(10, a_word);
        for (int p = 0; p < 3; p++) begin
            sdi = p[0];
            sck = 1'b1;
            idle(HALF);
            sck = 1'b0;
            idle(HALF);
            chk("R8 sdo idle", {31'd0, sdo}, {31'd0, seen[9]});
        end
        send(10, b_word);
        for (int k = 0; k < 10; k++)
            chk("R8 register untouched", {31'd0, seen[k]}, {31'd0, a_word[9-k]});
        check_all("R8 frame after stray clocks");

        // R6, R7: shutdown holds codes and accepts writes
        set_shdn(1'b1);
        check_all("R6 shutdown on");
        send(10, mk_word(2'b00, 8'h11));
        check_all("R7 write in shutdown");
        set_shdn(1'b0);
        check_all("R7 release keeps codes");

        // random frames mixed with shutdown toggles
        for (int i = 0; i < 40; i++) begin
            int r;
            r  = int'($urandom % 8);
            nb = (r == 0) ? 9 : (r == 1) ? 11 : 10;
            w  = $urandom & ((32'd1 << nb) - 1);
            if ($urandom % 4 == 0) set_shdn(~shdn_model);
            send(nb, w);
            check_all((nb == 10) ? "R2 random frame" : "R4 random bad frame");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule